// File: doc/BRIEF.md
# PMP Configuration Register Bank with Rule Locking

This block holds the configuration state for physical memory protection (PMP). It contains one global security configuration register, a parameterised number of 8-bit per-entry configuration bytes, and one address register for each entry. Software reaches all of it through a single CSR port: an address, write data, a write enable, and combinational read data. The reset input acts as the PMP reset and returns every register to zero.

Every CSR write passes through a filter before it reaches storage. The filter makes the global lockdown and deny-by-default bits sticky. It freezes the lock-bypass bit at zero once any entry carries a lock bit. It protects locked entries and the address register just below a locked top-of-range entry. Under lockdown it refuses config bytes that would create a new executable rule owned by machine mode. Each byte of a packed configuration word is judged on its own.

The current entries and the three global bits are exported as flat vectors for a separate permission checker.

Top module: `pmp_cfg_bank`

## Requirements
- R1: After reset, all configuration bytes, all address registers and all three global bits read as zero, both through the CSR port and on the exported outputs.
- R2: The security register at CSR 0x747 holds lockdown in bit 0, deny-by-default in bit 1 and lock bypass in bit 2, and all other bits read zero. Writing 1 sets lockdown or deny-by-default, and writing 0 leaves them set until reset. CSR 0x757 always reads zero and ignores writes.
- R3: A write to 0x747 loads bit 2 into lock bypass, unless bypass is 0 and at least one entry (enabled or not) has its lock bit set. In that case bypass stays 0.
- R4: With parameter HAS_RLB = 0, lock bypass always reads 0, whatever is written.
- R5: While bypass is 0, writes to the configuration byte or the address register of an entry whose lock bit (byte bit 7) is set are ignored. While bypass is 1 such writes take effect.
- R6: While bypass is 0, writes to address register i are ignored when entry i+1 is locked with address mode TOR (byte bits 4:3 = 01). Other address registers stay writable.
- R7: With lockdown set and bypass clear, a byte write is ignored (old value kept) when the new byte has lock = 1 and either {W,R} = 10 or X = 1 with {W,R} != 11. Lock = 1 with R = W = X = 1 is accepted, and with bypass set all such bytes are accepted.
- R8: With lockdown clear, a byte write with R = 0 and W = 1 (bits 0 and 1) is ignored. With lockdown set and lock clear that encoding is accepted.
- R9: CSR 0x3A0+k holds entries 4k..4k+3, entry 4k+j in bits 8j+7:8j. Each byte is accepted or rejected independently, and reserved byte bits 6:5 are stored as zero.
- R10: Address register i is at CSR 0x3B0+i. The exported configuration vector carries entry i in bits 8i+7:8i, the exported address vector carries entry i in its i-th slice, and the exported global bits match the security register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low PMP reset |
| csrAddr | input | 12 | CSR address |
| csrWe | input | 1 | CSR write enable |
| csrWdata | input | 32 | CSR write data |
| csrRdata | output | 32 | CSR read data for csrAddr (combinational) |
| cfgOut | output | N_ENTRIES*8 | All configuration bytes, entry i at 8i |
| addrOut | output | N_ENTRIES*ADDR_W | All address registers |
| lockdownOut | output | 1 | Lockdown global bit |
| denyDefaultOut | output | 1 | Deny-by-default global bit |
| lockBypassOut | output | 1 | Lock-bypass global bit |

## Verification
Several rules are checked on every cycle by assertions:
- the two sticky bits never fall;
- bypass never rises while a lock is present;
- a locked entry's byte and address, and the address under a locked TOR entry, hold still without bypass;
- no executable locked byte appears under lockdown;
- the R=0,W=1 encoding never appears while lockdown is clear.

Only the bench scenarios can show the positive side of these rules: that accepted bytes really land next to rejected ones in the same word, that the CSR and export mapping is right, that bypass re-opens locked entries, and that reset clears the freeze on bypass.

// File: rtl/pmp_bank_pkg.sv
package pmp_bank_pkg;

  localparam logic [11:0] CSR_SEC_LO    = 12'h747;
  localparam logic [11:0] CSR_SEC_HI    = 12'h757;
  localparam logic [11:0] CSR_CFG_BASE  = 12'h3A0;
  localparam logic [11:0] CSR_ADDR_BASE = 12'h3B0;

  localparam logic [1:0] MODE_TOR = 2'd1;
  localparam logic [7:0] CFG_KEEP_MASK = 8'h9F;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_SEC  = 2'd1,
    RD_CFG  = 2'd2,
    RD_ADDR = 2'd3
  } rdKind_e;

  // strobes from the decode control to the register datapath
  typedef struct packed {
    logic    secWe;
    logic    cfgWe;
    logic    addrWe;
    rdKind_e rdKind;
    logic [5:0] idx;
  } bankStrobe_t;

  typedef struct packed {
    logic       lock;
    logic [1:0] rsvd;
    logic [1:0] mode;
    logic       x;
    logic       w;
    logic       r;
  } pmpCfg_t;

endpackage

// File: rtl/pmp_bank_ctrl.sv
module pmp_bank_ctrl
  import pmp_bank_pkg::*;
#(
  parameter int N_ENTRIES = 16
) (
  input  logic [11:0]  csrAddr,
  input  logic         csrWe,
  output bankStrobe_t  stb
);

  localparam int CFG_WORDS = N_ENTRIES / 4;

  logic [11:0] cfgOff;
  logic [11:0] addrOff;

  assign cfgOff  = csrAddr - CSR_CFG_BASE;
  assign addrOff = csrAddr - CSR_ADDR_BASE;

  always_comb begin
    stb = '{secWe: 1'b0, cfgWe: 1'b0, addrWe: 1'b0, rdKind: RD_ZERO, idx: 6'd0};
    if (csrAddr == CSR_SEC_LO) begin
      stb.rdKind = RD_SEC;
      stb.secWe  = csrWe;
    end else if (csrAddr == CSR_SEC_HI) begin
      stb.rdKind = RD_ZERO;
    end else if (csrAddr >= CSR_CFG_BASE && cfgOff < 12'(CFG_WORDS)) begin
      stb.rdKind = RD_CFG;
      stb.cfgWe  = csrWe;
      stb.idx    = cfgOff[5:0];
    end else if (csrAddr >= CSR_ADDR_BASE && addrOff < 12'(N_ENTRIES)) begin
      stb.rdKind = RD_ADDR;
      stb.addrWe = csrWe;
      stb.idx    = addrOff[5:0];
    end
  end

endmodule

// File: rtl/pmp_cfg_filter.sv
module pmp_cfg_filter
  import pmp_bank_pkg::*;
(
  input  pmpCfg_t    oldCfg,
  input  logic [7:0] newByte,
  input  logic       lockdown,
  input  logic       lockBypass,
  output logic       accept,
  output pmpCfg_t    nextCfg
);

  logic entryFrozen;
  logic sharedEnc;
  logic execLocked;

  assign nextCfg     = pmpCfg_t'(newByte & CFG_KEEP_MASK);
  assign entryFrozen = oldCfg.lock && !lockBypass;
  assign sharedEnc   = !nextCfg.r && nextCfg.w;
  // locked shared code, or a machine-only rule that can execute
  assign execLocked  = nextCfg.lock &&
                       (sharedEnc || (nextCfg.x && !(nextCfg.r && nextCfg.w)));

  assign accept = !entryFrozen &&
                  !(sharedEnc && !lockdown) &&
                  !(lockdown && !lockBypass && execLocked);

endmodule

// File: rtl/pmp_bank_dp.sv
module pmp_bank_dp
  import pmp_bank_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int ADDR_W    = 32,
  parameter bit HAS_RLB   = 1'b1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  bankStrobe_t                   stb,
  input  logic [31:0]                   wdata,
  output logic [31:0]                   rdata,
  output logic [N_ENTRIES*8-1:0]        cfgFlat,
  output logic [N_ENTRIES*ADDR_W-1:0]   addrFlat,
  output logic                          lockdown,
  output logic                          denyDefault,
  output logic                          lockBypass
);

  localparam int CFG_WORDS = N_ENTRIES / 4;
  localparam int CIW = (CFG_WORDS > 1) ? $clog2(CFG_WORDS) : 1;
  localparam int AIW = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

  pmpCfg_t           cfgQ  [N_ENTRIES];
  logic [ADDR_W-1:0] addrQ [N_ENTRIES];
  logic [31:0]       cfgWord [CFG_WORDS];
  logic              anyLock;
  logic              bypassNext;

  always_comb begin
    anyLock = 1'b0;
    for (int i = 0; i < N_ENTRIES; i++) anyLock = anyLock | cfgQ[i].lock;
  end

  always_comb begin
    if (!HAS_RLB)                        bypassNext = 1'b0;
    else if (lockBypass || !anyLock)     bypassNext = wdata[2];
    else                                 bypassNext = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockdown    <= 1'b0;
      denyDefault <= 1'b0;
      lockBypass  <= 1'b0;
    end else if (stb.secWe) begin
      lockdown    <= lockdown | wdata[0];
      denyDefault <= denyDefault | wdata[1];
      lockBypass  <= bypassNext;
    end
  end

  AST_LOCKDOWN_STICKY: assert property (@(posedge clk) disable iff (!rstN) lockdown |=> lockdown); // R2
  AST_DENY_STICKY: assert property (@(posedge clk) disable iff (!rstN) denyDefault |=> denyDefault); // R2
  AST_BYPASS_FROZEN: assert property (@(posedge clk) disable iff (!rstN) (!lockBypass && anyLock) |=> !lockBypass); // R3

  generate
    if (!HAS_RLB) begin : g_noBypass
      AST_BYPASS_TIED: assert property (@(posedge clk) disable iff (!rstN) stb.secWe |=> !lockBypass); // R4
    end
  endgenerate

  for (genvar w = 0; w < CFG_WORDS; w++) begin : g_word
    assign cfgWord[w] = {cfgQ[4*w+3], cfgQ[4*w+2], cfgQ[4*w+1], cfgQ[4*w]};
  end

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_entry
    logic    accept;
    pmpCfg_t nextCfg;
    logic    addrGuard;
    logic    cfgWr;
    logic    addrWr;

    pmp_cfg_filter u_filter (
      .oldCfg     (cfgQ[i]),
      .newByte    (wdata[8*(i%4) +: 8]),
      .lockdown   (lockdown),
      .lockBypass (lockBypass),
      .accept     (accept),
      .nextCfg    (nextCfg)
    );

    if (i + 1 < N_ENTRIES) begin : g_torGuard
      assign addrGuard = !lockBypass &&
                         (cfgQ[i].lock || (cfgQ[i+1].lock && cfgQ[i+1].mode == MODE_TOR));
      AST_TOR_BELOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
        (!lockBypass && cfgQ[i+1].lock && cfgQ[i+1].mode == MODE_TOR) |=> $stable(addrQ[i])); // R6
    end else begin : g_lastGuard
      assign addrGuard = !lockBypass && cfgQ[i].lock;
    end

    assign cfgWr  = stb.cfgWe && (stb.idx == 6'(i / 4)) && accept;
    assign addrWr = stb.addrWe && (stb.idx == 6'(i)) && !addrGuard;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfgQ[i]  <= '0;
        addrQ[i] <= '0;
      end else begin
        if (cfgWr)  cfgQ[i]  <= nextCfg;
        if (addrWr) addrQ[i] <= wdata[ADDR_W-1:0];
      end
    end

    assign cfgFlat[8*i +: 8]           = cfgQ[i];
    assign addrFlat[ADDR_W*i +: ADDR_W] = addrQ[i];

    AST_LOCKED_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (cfgQ[i].lock && !lockBypass) |=> $stable(cfgQ[i])); // R5
    AST_LOCKED_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (cfgQ[i].lock && !lockBypass) |=> $stable(addrQ[i])); // R5
    AST_NO_EXEC_LOCK_ADD: assert property (@(posedge clk) disable iff (!rstN)
      (lockdown && !lockBypass && !cfgQ[i].lock) |=>
      !(cfgQ[i].lock && ((!cfgQ[i].r && cfgQ[i].w) || (cfgQ[i].x && !(cfgQ[i].r && cfgQ[i].w))))); // R7
    AST_SHARED_RESERVED: assert property (@(posedge clk) disable iff (!rstN)
      (!lockdown && !(!cfgQ[i].r && cfgQ[i].w)) |=> !(!cfgQ[i].r && cfgQ[i].w)); // R8
  end

  always_comb begin
    unique case (stb.rdKind)
      RD_SEC:  rdata = {29'd0, lockBypass, denyDefault, lockdown};
      RD_CFG:  rdata = cfgWord[stb.idx[CIW-1:0]];
      RD_ADDR: rdata = 32'(addrQ[stb.idx[AIW-1:0]]);
      default: rdata = 32'd0;
    endcase
  end

endmodule

// File: rtl/pmp_cfg_bank.sv
module pmp_cfg_bank
  import pmp_bank_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int ADDR_W    = 32,
  parameter bit HAS_RLB   = 1'b1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [11:0]                 csrAddr,
  input  logic                        csrWe,
  input  logic [31:0]                 csrWdata,
  output logic [31:0]                 csrRdata,
  output logic [N_ENTRIES*8-1:0]      cfgOut,
  output logic [N_ENTRIES*ADDR_W-1:0] addrOut,
  output logic                        lockdownOut,
  output logic                        denyDefaultOut,
  output logic                        lockBypassOut
);

  bankStrobe_t stb;

  pmp_bank_ctrl #(.N_ENTRIES(N_ENTRIES)) u_ctrl (
    .csrAddr (csrAddr),
    .csrWe   (csrWe),
    .stb     (stb)
  );

  pmp_bank_dp #(
    .N_ENTRIES (N_ENTRIES),
    .ADDR_W    (ADDR_W),
    .HAS_RLB   (HAS_RLB)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .wdata       (csrWdata),
    .rdata       (csrRdata),
    .cfgFlat     (cfgOut),
    .addrFlat    (addrOut),
    .lockdown    (lockdownOut),
    .denyDefault (denyDefaultOut),
    .lockBypass  (lockBypassOut)
  );

endmodule

// File: tb/pmp_cfg_bank_tb.sv
module pmp_cfg_bank_tb;
  localparam int N  = 16;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [11:0] csrAddr = '0;
  logic        csrWe = 1'b0;
  logic [31:0] csrWdata = '0;
  logic [31:0] csrRdata, nrRdata;
  logic [N*8-1:0]  cfgOut, nrCfg;
  logic [N*AW-1:0] addrOut, nrAddr;
  logic ldOut, ddOut, byOut, nrLd, nrDd, nrBy;

  pmp_cfg_bank #(.N_ENTRIES(N), .ADDR_W(AW), .HAS_RLB(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .csrAddr(csrAddr), .csrWe(csrWe), .csrWdata(csrWdata),
    .csrRdata(csrRdata), .cfgOut(cfgOut), .addrOut(addrOut),
    .lockdownOut(ldOut), .denyDefaultOut(ddOut), .lockBypassOut(byOut));

  pmp_cfg_bank #(.N_ENTRIES(N), .ADDR_W(AW), .HAS_RLB(1'b0)) u_dutNoRlb (
    .clk(clk), .rstN(rstN), .csrAddr(csrAddr), .csrWe(csrWe), .csrWdata(csrWdata),
    .csrRdata(nrRdata), .cfgOut(nrCfg), .addrOut(nrAddr),
    .lockdownOut(nrLd), .denyDefaultOut(nrDd), .lockBypassOut(nrBy));

  int vecCount = 0;
  int errCount = 0;

  logic [7:0]  mCfg  [N];
  logic [31:0] mAddr [N];
  logic mLd, mDd, mBy;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic mReset();
    for (int i = 0; i < N; i++) begin mCfg[i] = 8'h00; mAddr[i] = 32'h0; end
    mLd = 1'b0; mDd = 1'b0; mBy = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk) rstN = 1'b0;
    @(negedge clk);
    @(negedge clk) rstN = 1'b1;
    mReset();
  endtask

  function automatic logic [7:0] mFilter(input logic [7:0] oldB, input logic [7:0] newB);
    logic [7:0] n;
    n = newB & 8'h9F;
    if (oldB[7] && !mBy) return oldB;
    if (n[1:0] == 2'b10 && !mLd) return oldB;
    if (mLd && !mBy && n[7] && ((n[1:0] == 2'b10) || (n[2] && n[1:0] != 2'b11))) return oldB;
    return n;
  endfunction

  function automatic logic mAddrFrozen(input int i);
    if (mBy) return 1'b0;
    if (mCfg[i][7]) return 1'b1;
    if (i + 1 < N && mCfg[i+1][7] && mCfg[i+1][4:3] == 2'b01) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic mAnyLock();
    for (int i = 0; i < N; i++) if (mCfg[i][7]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] mRead(input logic [11:0] a);
    if (a == 12'h747) return {29'd0, mBy, mDd, mLd};
    if (a >= 12'h3A0 && a < 12'h3A0 + 12'(N/4)) begin
      int k = int'(a - 12'h3A0);
      return {mCfg[4*k+3], mCfg[4*k+2], mCfg[4*k+1], mCfg[4*k]};
    end
    if (a >= 12'h3B0 && a < 12'h3B0 + 12'(N)) return mAddr[int'(a - 12'h3B0)];
    return 32'h0;
  endfunction

  task automatic mWrite(input logic [11:0] a, input logic [31:0] d);
    if (a == 12'h747) begin
      if (mBy || !mAnyLock()) mBy = d[2];
      mLd = mLd | d[0];
      mDd = mDd | d[1];
    end else if (a >= 12'h3A0 && a < 12'h3A0 + 12'(N/4)) begin
      int k = int'(a - 12'h3A0);
      for (int j = 0; j < 4; j++) mCfg[4*k+j] = mFilter(mCfg[4*k+j], d[8*j +: 8]);
    end else if (a >= 12'h3B0 && a < 12'h3B0 + 12'(N)) begin
      int i = int'(a - 12'h3B0);
      if (!mAddrFrozen(i)) mAddr[i] = d;
    end
  endtask

  task automatic csrWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    csrAddr = a; csrWdata = d; csrWe = 1'b1;
    @(negedge clk);
    csrWe = 1'b0;
    mWrite(a, d);
  endtask

  task automatic readExp(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    csrAddr = a; csrWe = 1'b0;
    #1;
    check(req, csrRdata, exp);
  endtask

  task automatic checkExports(input string req);
    logic [N*8-1:0]  eCfg;
    logic [N*AW-1:0] eAddr;
    for (int i = 0; i < N; i++) begin
      eCfg[8*i +: 8]   = mCfg[i];
      eAddr[AW*i +: AW] = mAddr[i];
    end
    #1;
    vecCount++;
    if (cfgOut !== eCfg) begin errCount++; $display("FAIL %s: cfgOut actual %h expected %h", req, cfgOut, eCfg); end
    vecCount++;
    if (addrOut !== eAddr) begin errCount++; $display("FAIL %s: addrOut mismatch actual %h expected %h", req, addrOut, eAddr); end
    check(req, {29'd0, byOut, ddOut, ldOut}, {29'd0, mBy, mDd, mLd});
  endtask

  initial begin
    #2_000_000;
    errCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

  initial begin
    int unsigned seedInit;
    seedInit = $urandom(32'h1F2E3D4C);
    mReset();
    doReset();

    // R1 reset state
    readExp("R1", 12'h747, 32'h0);
    readExp("R1", 12'h3A0, 32'h0);
    readExp("R1", 12'h3B0, 32'h0);
    checkExports("R1");

    // R3 bypass writable while nothing locked; R4 tied instance
    csrWrite(12'h747, 32'h4);
    readExp("R3", 12'h747, 32'h4);
    #1 check("R4", nrRdata, 32'h0);
    // R2 high word reads zero, ignores writes
    csrWrite(12'h757, 32'hFFFF_FFFF);
    readExp("R2", 12'h757, 32'h0);
    readExp("R2", 12'h747, 32'h4);

    csrWrite(12'h3A0, 32'h0000_0080);
    readExp("R9", 12'h3A0, 32'h0000_0080);
    csrWrite(12'h747, 32'h0);
    readExp("R3", 12'h747, 32'h0);
    csrWrite(12'h747, 32'h4);
    readExp("R3", 12'h747, 32'h0);

    // R5 locked entry
    csrWrite(12'h3B0, 32'h0000_1234);
    readExp("R5", 12'h3B0, 32'h0);
    // R9 per-byte filter and reserved bits
    csrWrite(12'h3A0, 32'h0F6F_0F03);
    readExp("R9", 12'h3A0, 32'h0F0F_0F80);
    csrWrite(12'h3A0, 32'h0088_0F80);
    readExp("R9", 12'h3A0, 32'h0088_0F80);

    // R6 address under locked TOR entry
    csrWrite(12'h3B1, 32'h0000_AAAA);
    readExp("R6", 12'h3B1, 32'h0);
    csrWrite(12'h3B3, 32'h0000_5555);
    readExp("R6", 12'h3B3, 32'h0000_5555);
    csrWrite(12'h3B2, 32'h0000_7777);
    readExp("R5", 12'h3B2, 32'h0);

    // R8 shared encoding reserved without lockdown
    csrWrite(12'h3A1, 32'h0000_0002);
    readExp("R8", 12'h3A1, 32'h0);
    csrWrite(12'h3A1, 32'h0000_0001);
    readExp("R8", 12'h3A1, 32'h0000_0001);

    // R2 sticky bits
    csrWrite(12'h747, 32'h1);
    readExp("R2", 12'h747, 32'h1);
    csrWrite(12'h747, 32'h0);
    readExp("R2", 12'h747, 32'h1);
    csrWrite(12'h747, 32'h2);
    readExp("R2", 12'h747, 32'h3);

    // R7 executable locked rules refused under lockdown
    csrWrite(12'h3A1, 32'h028A_9F85);
    readExp("R7", 12'h3A1, 32'h0200_9F01);
    #1 check("R10", {24'd0, cfgOut[47:40]}, 32'h9F);
    checkExports("R10");

    // R1 reset clears everything, including the bypass freeze
    doReset();
    readExp("R1", 12'h747, 32'h0);
    readExp("R1", 12'h3A0, 32'h0);
    readExp("R1", 12'h3A1, 32'h0);
    readExp("R1", 12'h3B3, 32'h0);
    csrWrite(12'h747, 32'h5);
    readExp("R3", 12'h747, 32'h5);
    csrWrite(12'h3A2, 32'h0000_0085);
    readExp("R7", 12'h3A2, 32'h0000_0085);
    // R5 bypass reopens locked entry
    csrWrite(12'h3A2, 32'h0000_0003);
    readExp("R5", 12'h3A2, 32'h0000_0003);

    // random phase
    doReset();
    for (int it = 0; it < 600; it++) begin
      logic [11:0] a;
      logic [31:0] d;
      int sel;
      if (it % 150 == 149) doReset();
      sel = int'($urandom % 20);
      d = $urandom;
      if (sel < 2) begin
        a = 12'h747;
        if ($urandom % 4 != 0) d[0] = 1'b0;
        if ($urandom % 2 != 0) d[1] = 1'b0;
      end else if (sel < 11) begin
        a = 12'h3A0 + 12'($urandom % (N/4));
        for (int j = 0; j < 4; j++) if ($urandom % 8 != 0) d[8*j+7] = 1'b0;
      end else begin
        a = 12'h3B0 + 12'($urandom % N);
      end
      csrWrite(a, d);
      readExp("R9", a, mRead(a));
      if (it % 10 == 0) checkExports("R10");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end
endmodule